// File: doc/BRIEF.md
# Register-Write Target for a Two-Wire Serial Bus

This block is a write-only I2C target that feeds a small configuration register file. SCL and SDA come in from the pads. A fast system clock samples both lines. The block then decodes the bus framing and turns each data byte into a one-cycle write strobe, with an 8-bit register address and 8 bits of data. It acknowledges a byte by pulling SDA low through an open-drain output. At every other time it leaves the line released.

A transfer opens with START and a byte holding the 7-bit device address plus a direction bit. The next byte sets the internal register pointer. Each byte after that is written to the register the pointer names, and the pointer then steps on by one. So one transfer can fill a run of consecutive registers, and it ends at STOP. A START that arrives before STOP returns the block to address reception.

Top module: `i2c_cfg_target`

## Requirements
- R1: While reset is asserted and right after it is released, the SDA pull-down output and the write strobe are both 0.
- R2: START is SDA falling while SCL is high. For the first byte after START (received MSB first), the block pulls SDA low during the ninth SCL pulse only when bits 7..1 equal `DEV_ADDR` and bit 0 (direction) is 0 (write).
- R3: If the address does not match, or bit 0 is 1 (read), the block gives no acknowledge. It then ignores all bytes, gives no acknowledge and makes no writes until the next START.
- R4: The second byte of an addressed write is acknowledged and loaded into the pointer. It produces no write strobe.
- R5: Each later byte is acknowledged and produces exactly one one-cycle write strobe. The strobe carries the pointer value as the address and the byte, assembled MSB first, as the data.
- R6: After each data write the pointer increments modulo 256. Any number of data bytes is accepted before STOP.
- R7: Outside the acknowledge bit, the block never pulls SDA low. The pull-down is asserted only after the SCL falling edge that ends bit 8 and is released after the falling edge that ends bit 9.
- R8: STOP (SDA rising while SCL is high) or START at any point aborts the current byte without writing it. After a START, the next byte is treated as an address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line from the pad |
| sda_i | input | 1 | Bus data line from the pad |
| sda_pull_o | output | 1 | 1 drives SDA low (open drain), 0 releases the line |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address for the write |
| wr_data_o | output | 8 | Data for the write |

## Verification
The hardest states to reach from the ports are the aborts: a START or STOP that lands partway through a data byte, after the pointer is set but before the byte's eighth bit. The bench drives a bus model that clocks out only a few bits of a byte and then issues a repeated START or a STOP. It then checks that the partial byte is never written, and that the next complete transfer writes exactly where its own pointer byte says. Before that, a sweep over all 128 device addresses checks that the acknowledge appears for exactly one of them.

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_DATA, S_SKIP} phase_t;

  logic [2:0] scl_q, sda_q;
  phase_t     phase;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, ptr;
  logic       ack;

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_s & ~scl_q[2];
  wire scl_fall  = ~scl_s & scl_q[2];
  wire start_det = scl_s & scl_q[2] & ~sda_s & sda_q[2];
  wire stop_det  = scl_s & scl_q[2] & sda_s & ~sda_q[2];
  wire busy      = (phase != S_IDLE) && (phase != S_SKIP);

  assign sda_pull_o = ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= '1;
      sda_q     <= '1;
      phase     <= S_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ptr       <= '0;
      ack       <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      scl_q   <= {scl_q[1:0], scl_i};
      sda_q   <= {sda_q[1:0], sda_i};
      wr_en_o <= 1'b0;
      if (start_det) begin
        phase   <= S_ADDR;
        bit_cnt <= '0;
        ack     <= 1'b0;
      end else if (stop_det) begin
        phase   <= S_IDLE;
        bit_cnt <= '0;
        ack     <= 1'b0;
      end else if (busy) begin
        if (scl_rise && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
          case (phase)
            S_ADDR: begin
              if (shreg == {DEV_ADDR, 1'b0}) ack <= 1'b1;
              else phase <= S_SKIP;
            end
            S_PTR: begin
              ack <= 1'b1;
              ptr <= shreg;
            end
            default: begin
              ack       <= 1'b1;
              wr_en_o   <= 1'b1;
              wr_addr_o <= ptr;
              wr_data_o <= shreg;
              ptr       <= ptr + 8'd1;
            end
          endcase
        end else if (scl_fall && bit_cnt == 4'd9) begin
          ack     <= 1'b0;
          bit_cnt <= '0;
          if (phase == S_ADDR) phase <= S_PTR;
          else if (phase == S_PTR) phase <= S_DATA;
        end
      end
    end
  end

endmodule

module i2c_cfg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_det,
  input logic sda_pull_o,
  input logic wr_en_o
);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> (!sda_pull_o && !wr_en_o));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  a_r5_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> sda_pull_o);

  a_r7_ack_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !$past(scl_s));

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull_o && !wr_en_o));

endmodule

bind i2c_cfg_target i2c_cfg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_pull_o(sda_pull_o), .wr_en_o(wr_en_o)
);

// File: tb/test_i2c_cfg_target.sv
module test_i2c_cfg_target;
  localparam int CLK_P = 10;
  localparam int Q = 8 * CLK_P;
  localparam logic [6:0] DEV = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_o, wr_en_o;
  logic [7:0] wr_addr_o, wr_data_o;
  wire sda_line = sda_m & ~sda_pull_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] log_a [256];
  logic [7:0] log_d [256];
  int n_wr = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_cfg_target #(.DEV_ADDR(DEV)) i_i2c_cfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always @(posedge clk) if (wr_en_o) begin
    log_a[n_wr % 256] <= wr_addr_o;
    log_d[n_wr % 256] <= wr_data_o;
    n_wr <= n_wr + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; #Q; scl_m = 1'b1; #(Q/2);
      check(sda_pull_o == 1'b0, "R7 data bit", sda_pull_o, 0);
      #(Q/2); scl_m = 1'b0; #Q;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    send_bits(b, 8);
    sda_m = 1'b1; #Q; scl_m = 1'b1; #(Q/2);
    check(sda_pull_o == exp_ack, req, sda_pull_o, exp_ack);
    #(Q/2); scl_m = 1'b0; #Q;
  endtask

  task automatic expect_writes(input int base, input int n, input logic [7:0] a0,
                               input logic [7:0] d0, input logic [7:0] dstep, input string req);
    check(n_wr - base == n, req, n_wr - base, n);
    for (int i = 0; i < n && i < n_wr - base; i++) begin
      logic [7:0] ea, ed;
      ea = a0 + 8'(i);
      ed = d0 + 8'(i) * dstep;
      check(log_a[(base + i) % 256] == ea, {req, " addr"}, log_a[(base + i) % 256], ea);
      check(log_d[(base + i) % 256] == ed, {req, " data"}, log_d[(base + i) % 256], ed);
    end
  endtask

  initial begin
    int base;
    #(3 * CLK_P + 2);
    check(sda_pull_o == 1'b0 && wr_en_o == 1'b0, "R1 in reset", {sda_pull_o, wr_en_o}, 0);
    rst_n = 1'b1;
    #(4 * CLK_P);
    check(sda_pull_o == 1'b0 && wr_en_o == 1'b0, "R1 after reset", {sda_pull_o, wr_en_o}, 0);

    // R2: sweep all device addresses, ack only on the match
    base = n_wr;
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, 7'(a) == DEV, "R2 address ack");
      bus_stop();
    end
    check(n_wr == base, "R2 no writes from address-only", n_wr - base, 0);

    // R3: read request and mismatched address ignore later bytes
    base = n_wr;
    bus_start();
    send_byte({DEV, 1'b1}, 1'b0, "R3 read nack");
    send_byte(8'h10, 1'b0, "R3 ignored byte");
    send_byte(8'h55, 1'b0, "R3 ignored byte");
    bus_stop();
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, "R3 mismatch nack");
    send_byte(8'h20, 1'b0, "R3 ignored byte");
    send_byte(8'hAA, 1'b0, "R3 ignored byte");
    bus_stop();
    check(n_wr == base, "R3 no writes", n_wr - base, 0);

    // R4: pointer only
    base = n_wr;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R4 address");
    send_byte(8'h20, 1'b1, "R4 pointer ack");
    bus_stop();
    check(n_wr == base, "R4 pointer makes no write", n_wr - base, 0);

    // R5/R6: bursts at several pointers, including wrap past 0xFF
    for (int pi = 0; pi < 3; pi++) begin
      for (int n = 1; n <= 4; n++) begin
        logic [7:0] p, d0;
        p  = (pi == 0) ? 8'h00 : (pi == 1) ? 8'h37 : 8'hFD;
        d0 = p * 8'd5 + 8'(n);
        base = n_wr;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R2 address");
        send_byte(p, 1'b1, "R4 pointer ack");
        for (int i = 0; i < n; i++)
          send_byte(d0 + 8'(i) * 8'd29, 1'b1, "R5 data ack");
        bus_stop();
        expect_writes(base, n, p, d0, 8'd29, "R6 burst");
      end
    end

    // R6: long burst
    base = n_wr;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address");
    send_byte(8'hF0, 1'b1, "R4 pointer ack");
    for (int i = 0; i < 20; i++) send_byte(8'h81 + 8'(i) * 8'd3, 1'b1, "R6 long ack");
    bus_stop();
    expect_writes(base, 20, 8'hF0, 8'h81, 8'd3, "R6 long burst");

    // R8: repeated START mid-byte
    base = n_wr;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address");
    send_byte(8'h40, 1'b1, "R4 pointer ack");
    send_bits(8'hFF, 4);
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R8 address after restart");
    send_byte(8'h50, 1'b1, "R8 pointer ack");
    send_byte(8'hA5, 1'b1, "R8 data ack");
    bus_stop();
    expect_writes(base, 1, 8'h50, 8'hA5, 8'd0, "R8 restart mid-byte");

    // R8: STOP mid-byte, then a normal transfer
    base = n_wr;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address");
    send_byte(8'h60, 1'b1, "R4 pointer ack");
    send_bits(8'h0F, 5);
    bus_stop();
    check(n_wr == base, "R8 stop drops partial byte", n_wr - base, 0);
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address");
    send_byte(8'h61, 1'b1, "R4 pointer ack");
    send_byte(8'h3C, 1'b1, "R5 data ack");
    bus_stop();
    expect_writes(base, 1, 8'h61, 8'h3C, 8'd0, "R8 after stop");

    // R8: repeated START after a full data byte
    base = n_wr;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address");
    send_byte(8'h70, 1'b1, "R4 pointer ack");
    send_byte(8'h11, 1'b1, "R5 data ack");
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R8 readdress");
    send_byte(8'h71, 1'b1, "R8 pointer ack");
    send_byte(8'h22, 1'b1, "R5 data ack");
    bus_stop();
    expect_writes(base, 2, 8'h70, 8'h11, 8'h11, "R8 restart between bytes");

    #(4 * CLK_P);
    check(sda_pull_o == 1'b0, "R7 idle release", sda_pull_o, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * CLK_P);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule